// File: doc/BRIEF.md
# Four-Bank Word-Interleaved Block Memory

This block is a memory made of four independent banks, each one data word wide, with consecutive word addresses spread across the banks. A requester reads a block of one, two or four words, or writes a single word. For a block read, the controller first spends a fixed address-send time. It then starts every bank the block needs in the same cycle, so the whole block costs one bank access time. After that it returns the words one per transfer slot over a single word-wide return path. Only the transfers are serialised, so a four-word block costs 4 + 24 + 16 = 44 cycles with the default timing, where four separate single-word reads would cost 128.

Each bank holds its contents in an internal register array. After it starts an access, a bank stays busy for its access time plus a recovery time. A request that needs a busy bank finishes its send phase and then waits until every bank it needs is free. The controller takes one request at a time. `req_ready` is high only while it is idle, and a request is taken on a rising edge where `req_valid` and `req_ready` are both high.

Top module: `ilv_mem`

## Requirements
- R1: The word at word address a is stored in bank (a mod 4), row (a div 4). A read returns the last value written to that address, and a write to one address leaves every other address unchanged.
- R2: Cycle 1 is the cycle that follows the accepting edge. If the bank it needs is free, a single-word read (req_len = 0) raises rd_valid with its word in cycle SEND_CYC + ACCESS_CYC + XFER_CYC, which is 32 by default.
- R3: If all its banks are free, a two-word read (req_len = 1) raises rd_valid in cycles 32 and 36, and a four-word read (req_len = 2) raises it in cycles 32, 36, 40 and 44. Words come in ascending address order from the block base, and rd_last is high only with the final word. All banks of a block start their access in the same cycle.
- R4: rd_valid is high only in the last cycle of each transfer slot, exactly once per word of the block, and never outside a read.
- R5: For a read, the request is rejected if req_len = 3, or if req_addr is not a multiple of the block word count (2^req_len). A rejected request raises req_err for exactly cycle 1 and starts no bank. It produces no rd_valid or wr_done, and req_ready stays high.
- R6: A write (req_write = 1) stores req_wdata into the addressed bank only and ignores req_len. wr_done pulses in cycle SEND_CYC + ACCESS_CYC, which is 28 by default.
- R7: A bank that starts an access in cycle s stays busy through cycle s + ACCESS_CYC + RECOVER_CYC. A request whose send phase ends while a needed bank is busy starts in the first cycle in which every needed bank is free, and all its later events shift by the same amount. Requests to other banks are not delayed.
- R8: req_ready is 1 while the controller is idle and 0 from cycle 1 of an accepted request up to its final event (rd_last or wr_done). Only one request is in flight at a time.
- R9: While reset is active and after it is released, req_ready = 1 and rd_valid, rd_last, wr_done and req_err are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = single-word write, 0 = block read |
| req_len | input | LEN_W (2) | Block size code: 0 = 1 word, 1 = 2 words, 2 = 4 words, 3 = reserved |
| req_addr | input | ADDR_W (8) | Word address; block base for reads |
| req_wdata | input | DATA_W (32) | Write data |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_err | output | 1 | One-cycle pulse on a rejected read |
| wr_done | output | 1 | One-cycle pulse when a write completes |
| rd_valid | output | 1 | Read word present on rd_data |
| rd_last | output | 1 | Marks the final word of a block |
| rd_data | output | DATA_W (32) | Read data word |

## Verification
The bench models each bank's busy window on its own. From that model it predicts the exact cycle of every strobe, so any design that skips the wait on a busy bank, or waits on a bank it does not need, puts its strobes in the wrong cycle. Reads of misaligned blocks and of the reserved length are followed at once by reads of the same banks. A design that started those banks anyway would delay the follow-up read, and one that wrote during a rejected request would corrupt data. A write to another row of the same bank, followed by a block read, shows whether bank and row decoding are swapped or whether a write spills into a neighbouring bank. The last address in the space is also exercised, to show whether the row field is truncated.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SEND   = 2'd1,
      ST_ACCESS = 2'd2,
      ST_XFER   = 2'd3
   } ilv_state_e;

   function automatic int imax3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
   parameter int DATA_W   = 32,
   parameter int ROW_W    = 6,
   parameter int BUSY_CYC = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              we_i,
   input  logic [ROW_W-1:0]  row_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              busy_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int ROWS   = 1 << ROW_W;
   localparam int BUSY_W = $clog2(BUSY_CYC + 1);

   logic [DATA_W-1:0] store [ROWS];
   logic [BUSY_W-1:0] busy_cnt;
   logic [DATA_W-1:0] rdata_q;

   initial begin : g_param_chk
      assert (BUSY_CYC >= 1) else $error("ilv_bank: BUSY_CYC must be at least 1");
      assert (ROW_W >= 1) else $error("ilv_bank: ROW_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (start_i && we_i) begin
         store[row_i] <= wdata_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_cnt <= '0;
         rdata_q  <= '0;
      end else if (start_i) begin
         busy_cnt <= BUSY_W'(BUSY_CYC);
         if (!we_i) begin
            rdata_q <= store[row_i];
         end
      end else if (busy_cnt != '0) begin
         busy_cnt <= busy_cnt - 1'b1;
      end
   end

   assign busy_o  = (busy_cnt != '0);
   assign rdata_o = rdata_q;

   // R7: the sequencer never starts a bank inside its busy window
   p_start_free_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o);

   // R7: read data held steady for the whole busy window
   p_rdata_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !start_i) |=> $stable(rdata_o));
endmodule

// File: rtl/ilv_lane_map.sv
module ilv_lane_map #(
   parameter int DATA_W    = 32,
   parameter int BANK_LOG2 = 2,
   parameter int LEN_W     = 2
) (
   input  logic [BANK_LOG2-1:0] base_bank_i,
   input  logic [LEN_W-1:0]     lenc_i,
   input  logic [BANK_LOG2:0]   slot_i,
   input  logic [DATA_W-1:0]    bank_rdata_i [1 << BANK_LOG2],
   output logic [(1 << BANK_LOG2)-1:0] need_mask_o,
   output logic [DATA_W-1:0]    sel_data_o
);
   localparam int NUM_BANKS = 1 << BANK_LOG2;

   logic [BANK_LOG2-1:0] sel_idx;

   for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_need
      logic [BANK_LOG2-1:0] lane_off;
      assign lane_off       = BANK_LOG2'(gi) - base_bank_i;
      assign need_mask_o[gi] = (int'(lane_off) < (1 << int'(lenc_i)));
   end

   assign sel_idx    = base_bank_i + slot_i[BANK_LOG2-1:0];
   assign sel_data_o = bank_rdata_i[sel_idx];
endmodule

// File: rtl/ilv_seq.sv
module ilv_seq
   import ilv_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 8,
   parameter int BANK_LOG2    = 2,
   parameter int LEN_W        = 2,
   parameter int MAX_LEN_LOG2 = 2,
   parameter int SEND_CYC     = 4,
   parameter int ACCESS_CYC   = 24,
   parameter int XFER_CYC     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [(1 << BANK_LOG2)-1:0] need_mask_i,
   input  logic [(1 << BANK_LOG2)-1:0] bank_busy_i,
   output logic              req_ready,
   output logic              req_err,
   output logic              wr_done,
   output logic              rd_valid,
   output logic              rd_last,
   output logic              start_o,
   output logic              cur_write_o,
   output logic [LEN_W-1:0]  cur_lenc_o,
   output logic [ADDR_W-1:0] cur_addr_o,
   output logic [DATA_W-1:0] cur_wdata_o,
   output logic [BANK_LOG2:0] slot_o
);
   localparam int MAXC   = imax3(SEND_CYC, ACCESS_CYC, XFER_CYC);
   localparam int CNT_W  = $clog2(MAXC + 1);
   localparam int SLOT_W = BANK_LOG2 + 1;

   ilv_state_e        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [SLOT_W-1:0] slot_q;
   logic              write_q;
   logic [LEN_W-1:0]  lenc_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              err_q;

   logic              accept;
   logic              len_bad;
   logic [ADDR_W-1:0] low_mask;
   logic              rd_reject;
   logic              banks_free;
   logic              cnt_zero;
   logic [SLOT_W-1:0] last_slot;

   assign accept     = req_valid && (state_q == ST_IDLE);
   assign len_bad    = (int'(req_len) > MAX_LEN_LOG2);
   assign low_mask   = ADDR_W'((32'd1 << req_len) - 32'd1);
   assign rd_reject  = !req_write && (len_bad || ((req_addr & low_mask) != '0));
   assign banks_free = ((need_mask_i & bank_busy_i) == '0);
   assign cnt_zero   = (cnt_q == '0);
   assign last_slot  = SLOT_W'((32'd1 << lenc_q) - 32'd1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         slot_q  <= '0;
         write_q <= 1'b0;
         lenc_q  <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         err_q   <= 1'b0;
      end else begin
         err_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (rd_reject) begin
                     err_q <= 1'b1;
                  end else begin
                     state_q <= ST_SEND;
                     cnt_q   <= CNT_W'(SEND_CYC - 1);
                     write_q <= req_write;
                     lenc_q  <= req_write ? '0 : req_len;
                     addr_q  <= req_addr;
                     wdata_q <= req_wdata;
                     slot_q  <= '0;
                  end
               end
            end
            ST_SEND: begin
               if (!cnt_zero) begin
                  cnt_q <= cnt_q - 1'b1;
               end else if (banks_free) begin
                  state_q <= ST_ACCESS;
                  cnt_q   <= CNT_W'(ACCESS_CYC - 1);
               end
            end
            ST_ACCESS: begin
               if (!cnt_zero) begin
                  cnt_q <= cnt_q - 1'b1;
               end else if (write_q) begin
                  state_q <= ST_IDLE;
               end else begin
                  state_q <= ST_XFER;
                  cnt_q   <= CNT_W'(XFER_CYC - 1);
                  slot_q  <= '0;
               end
            end
            ST_XFER: begin
               if (!cnt_zero) begin
                  cnt_q <= cnt_q - 1'b1;
               end else if (slot_q == last_slot) begin
                  state_q <= ST_IDLE;
               end else begin
                  slot_q <= slot_q + 1'b1;
                  cnt_q  <= CNT_W'(XFER_CYC - 1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready   = (state_q == ST_IDLE);
   assign req_err     = err_q;
   assign start_o     = (state_q == ST_SEND) && cnt_zero && banks_free;
   assign wr_done     = (state_q == ST_ACCESS) && cnt_zero && write_q;
   assign rd_valid    = (state_q == ST_XFER) && cnt_zero;
   assign rd_last     = rd_valid && (slot_q == last_slot);
   assign cur_write_o = write_q;
   assign cur_lenc_o  = lenc_q;
   assign cur_addr_o  = addr_q;
   assign cur_wdata_o = wdata_q;
   assign slot_o      = slot_q;

   // R5: a rejection leaves the controller idle with no read strobe
   p_err_idle_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> (req_ready && !rd_valid && !wr_done));

   // R6: a finished write frees the controller on the next cycle
   p_wr_idle_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> req_ready);

   // R3: the final word of a block returns the controller to idle
   p_last_idle_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      rd_last |=> req_ready);
endmodule

// File: rtl/ilv_mem.sv
module ilv_mem #(
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 8,
   parameter int BANK_LOG2    = 2,
   parameter int LEN_W        = 2,
   parameter int MAX_LEN_LOG2 = 2,
   parameter int SEND_CYC     = 4,
   parameter int ACCESS_CYC   = 24,
   parameter int XFER_CYC     = 4,
   parameter int RECOVER_CYC  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              req_err,
   output logic              wr_done,
   output logic              rd_valid,
   output logic              rd_last,
   output logic [DATA_W-1:0] rd_data
);
   localparam int NUM_BANKS = 1 << BANK_LOG2;
   localparam int ROW_W     = ADDR_W - BANK_LOG2;
   localparam int BUSY_CYC  = ACCESS_CYC + RECOVER_CYC;

   initial begin : g_param_chk
      assert (BANK_LOG2 >= 1) else $error("ilv_mem: need at least two banks");
      assert (ADDR_W > BANK_LOG2) else $error("ilv_mem: ADDR_W too small for the bank count");
      assert (MAX_LEN_LOG2 <= BANK_LOG2)
         else $error("ilv_mem: a block may not span more words than there are banks");
      assert (MAX_LEN_LOG2 < (1 << LEN_W)) else $error("ilv_mem: LEN_W too narrow");
      assert (SEND_CYC >= 1 && ACCESS_CYC >= 1 && XFER_CYC >= 1)
         else $error("ilv_mem: phase lengths must be at least one cycle");
      assert (RECOVER_CYC >= 0) else $error("ilv_mem: RECOVER_CYC must not be negative");
   end

   logic                  start;
   logic                  cur_write;
   logic [LEN_W-1:0]      cur_lenc;
   logic [ADDR_W-1:0]     cur_addr;
   logic [DATA_W-1:0]     cur_wdata;
   logic [BANK_LOG2:0]    slot;
   logic [NUM_BANKS-1:0]  need_mask;
   logic [NUM_BANKS-1:0]  busy_vec;
   logic [NUM_BANKS-1:0]  start_vec;
   logic [DATA_W-1:0]     bank_rdata [NUM_BANKS];

   ilv_seq #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BANK_LOG2(BANK_LOG2), .LEN_W(LEN_W),
      .MAX_LEN_LOG2(MAX_LEN_LOG2), .SEND_CYC(SEND_CYC), .ACCESS_CYC(ACCESS_CYC),
      .XFER_CYC(XFER_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_len(req_len),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .need_mask_i(need_mask), .bank_busy_i(busy_vec),
      .req_ready(req_ready), .req_err(req_err), .wr_done(wr_done),
      .rd_valid(rd_valid), .rd_last(rd_last), .start_o(start),
      .cur_write_o(cur_write), .cur_lenc_o(cur_lenc), .cur_addr_o(cur_addr),
      .cur_wdata_o(cur_wdata), .slot_o(slot)
   );

   ilv_lane_map #(
      .DATA_W(DATA_W), .BANK_LOG2(BANK_LOG2), .LEN_W(LEN_W)
   ) u_map (
      .base_bank_i(cur_addr[BANK_LOG2-1:0]), .lenc_i(cur_lenc), .slot_i(slot),
      .bank_rdata_i(bank_rdata), .need_mask_o(need_mask), .sel_data_o(rd_data)
   );

   for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
      assign start_vec[gb] = start && need_mask[gb];
      ilv_bank #(
         .DATA_W(DATA_W), .ROW_W(ROW_W), .BUSY_CYC(BUSY_CYC)
      ) u_bank (
         .clk(clk), .rst_n(rst_n), .start_i(start_vec[gb]), .we_i(cur_write),
         .row_i(cur_addr[ADDR_W-1:BANK_LOG2]), .wdata_i(cur_wdata),
         .busy_o(busy_vec[gb]), .rdata_o(bank_rdata[gb])
      );
   end

   // R3: every bank started for a block is busy together on the next cycle
   p_block_busy_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (start_vec != '0) |=> ((busy_vec & $past(start_vec)) == $past(start_vec)));

   // R4: no read strobe while a write is in flight
   p_no_strobe_on_write_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && cur_write) |-> !rd_valid);
endmodule

// File: tb/ilv_mem_tb.sv
module ilv_mem_tb;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 8;
   localparam int NB     = 4;
   localparam int SEND   = 4;
   localparam int ACCESS = 24;
   localparam int XFER   = 4;
   localparam int RECOV  = 8;
   localparam int WD_LIMIT = 20000;
   localparam int NVEC   = 20;

   // {write, len code, word address, data}
   localparam logic [42:0] VEC [NVEC] = '{
      {1'b1, 2'd0, 8'h10, 32'hA000_0010},
      {1'b1, 2'd0, 8'h11, 32'hA000_0011},
      {1'b1, 2'd0, 8'h12, 32'hA000_0012},
      {1'b1, 2'd0, 8'h13, 32'hA000_0013},
      {1'b0, 2'd1, 8'h10, 32'h0},
      {1'b0, 2'd2, 8'h10, 32'h0},
      {1'b0, 2'd0, 8'h13, 32'h0},
      {1'b1, 2'd3, 8'h14, 32'hB000_0014},
      {1'b0, 2'd0, 8'h10, 32'h0},
      {1'b0, 2'd0, 8'h14, 32'h0},
      {1'b0, 2'd1, 8'h12, 32'h0},
      {1'b0, 2'd1, 8'h11, 32'h0},
      {1'b0, 2'd2, 8'h12, 32'h0},
      {1'b0, 2'd3, 8'h10, 32'h0},
      {1'b0, 2'd0, 8'h12, 32'h0},
      {1'b1, 2'd0, 8'h11, 32'hC000_0011},
      {1'b0, 2'd2, 8'h10, 32'h0},
      {1'b1, 2'd0, 8'hFF, 32'hD000_00FF},
      {1'b0, 2'd0, 8'hFF, 32'h0},
      {1'b0, 2'd0, 8'h11, 32'h0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [1:0]        req_len = '0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              req_ready, req_err, wr_done, rd_valid, rd_last;
   logic [DATA_W-1:0] rd_data;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int free_from [NB];
   logic [DATA_W-1:0] mem_m [1 << ADDR_W];

   always #10 clk = ~clk;

   ilv_mem u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_len(req_len), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ready(req_ready), .req_err(req_err), .wr_done(wr_done),
      .rd_valid(rd_valid), .rd_last(rd_last), .rd_data(rd_data)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WD_LIMIT) begin
         checks = checks + 1;
         errors = errors + 1;
         $display("FAIL R8 watchdog: got cycle %0d expected below %0d", cyc, WD_LIMIT);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic do_op(input bit wr, input logic [1:0] lenc,
                        input logic [ADDR_W-1:0] addr, input logic [DATA_W-1:0] wd);
      int acc, s, nw, last_c, bad_cyc, k;
      bit bad, ok_t, ok_r, waited, exp_v, exp_w;
      logic got_v, got_w;
      string tag;
      while (req_ready !== 1'b1) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_len = lenc; req_addr = addr; req_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      acc = cyc;
      req_valid = 1'b0;
      bad = !wr && (lenc == 2'd3 || (int'(addr) % (1 << lenc)) != 0);
      chk(req_err === bad, "R5", "error pulse in cycle 1", 32'(req_err), 32'(bad));
      if (bad) begin
         ok_t = 1'b1;
         repeat (40) begin
            @(negedge clk);
            if (rd_valid !== 1'b0 || wr_done !== 1'b0 || req_ready !== 1'b1 || req_err !== 1'b0)
               ok_t = 1'b0;
         end
         chk(ok_t, "R5", "quiet after rejected read", 32'(ok_t), 32'd1);
         return;
      end
      nw = wr ? 1 : (1 << lenc);
      s  = acc + SEND - 1;
      for (int i = 0; i < nw; i++) begin
         if (free_from[(int'(addr) + i) % NB] > s) s = free_from[(int'(addr) + i) % NB];
      end
      waited = (s > acc + SEND - 1);
      for (int i = 0; i < nw; i++) free_from[(int'(addr) + i) % NB] = s + ACCESS + RECOV + 1;
      last_c = wr ? s + ACCESS : s + ACCESS + nw * XFER;
      ok_t = 1'b1; ok_r = 1'b1; bad_cyc = -1; got_v = 1'b0; got_w = 1'b0;
      exp_v = 1'b0; exp_w = 1'b0;
      while (cyc <= last_c) begin
         exp_v = !wr && (cyc > s + ACCESS) && (((cyc - s - ACCESS) % XFER) == 0);
         exp_w = wr && (cyc == s + ACCESS);
         if ((rd_valid !== exp_v || wr_done !== exp_w) && ok_t) begin
            ok_t = 1'b0; bad_cyc = cyc - acc + 1; got_v = rd_valid; got_w = wr_done;
         end
         if (req_ready !== 1'b0) ok_r = 1'b0;
         if (exp_v && rd_valid === 1'b1) begin
            k = (cyc - s - ACCESS) / XFER - 1;
            chk(rd_data === mem_m[int'(addr) + k], "R1", "read word data",
                rd_data, mem_m[int'(addr) + k]);
            chk(rd_last === (k == nw - 1), "R3", "last marker",
                32'(rd_last), 32'(k == nw - 1));
         end
         @(negedge clk);
      end
      if (wr) tag = "R6";
      else if (waited) tag = "R7";
      else if (nw == 1) tag = "R2";
      else tag = "R3";
      if (!ok_t)
         $display("FAIL %s R4 strobe timing at cycle %0d: got valid=%b wr_done=%b expected valid=%b wr_done=%b",
                  tag, bad_cyc, got_v, got_w, !got_v && !wr, !got_w && wr);
      checks = checks + 1;
      if (!ok_t) errors = errors + 1;
      chk(ok_r, "R8", "ready low while busy", 32'(ok_r), 32'd1);
      if (wr) mem_m[addr] = wd;
   endtask

   initial begin
      for (int b = 0; b < NB; b++) free_from[b] = 0;
      for (int a = 0; a < (1 << ADDR_W); a++) mem_m[a] = '0;
      repeat (3) @(negedge clk);
      // R9: state during reset
      chk(req_ready === 1'b1, "R9", "ready in reset", 32'(req_ready), 32'd1);
      chk(rd_valid === 1'b0 && rd_last === 1'b0, "R9", "no strobe in reset",
          32'({rd_valid, rd_last}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1, "R9", "ready after reset", 32'(req_ready), 32'd1);
      chk(wr_done === 1'b0 && req_err === 1'b0, "R9", "no pulses after reset",
          32'({wr_done, req_err}), 32'd0);

      for (int i = 0; i < NVEC; i++) begin
         do_op(VEC[i][42], VEC[i][41:40], VEC[i][39:32], VEC[i][31:0]);
      end

      // R7: back-to-back write then block read over the same banks waits
      do_op(1'b1, 2'd0, 8'h22, 32'hE000_0022);
      do_op(1'b0, 2'd2, 8'h20, 32'h0);
      // R2: read of a bank untouched since long ago is not delayed
      repeat (50) @(negedge clk);
      do_op(1'b0, 2'd0, 8'h13, 32'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule